// File: doc/BRIEF.md
# Field Counter with Field-Rate Detection

This block measures the length of each video field by counting half-line ticks (a strobe at twice the line rate) between successive vertical sync strobes. The strobe is taken from an upstream noise filter. At each field boundary the measured length is sorted into one of two field standards: more than 287 lines per field means 50 Hz, and anything shorter means 60 Hz. A registered standard flag follows that result. The flag changes only after two consecutive fields agree, so one disturbed field cannot toggle it.

The same half-line count drives the vertical timing. A vertical output pulse starts at each sync reference and lasts ten half-line ticks. A vertical blanking window opens shortly before the expected next reference and closes some lines after it, and the window limits depend on the current standard. If no sync arrives, the 10-bit counter stops at its maximum value. The block then enters a lost state, raises a missing-sync flag and holds the picture blanked until a strobe returns.

The control state machine has three states. HUNT is entered at reset and after a loss; it waits for a first reference. TRACK counts and classifies fields. LOST holds while the counter is saturated. The transitions are:
- reset to HUNT
- HUNT to TRACK on a sync strobe, with no classification
- HUNT or TRACK to LOST when the counter is saturated and no strobe arrives
- TRACK to TRACK on a strobe, classifying the field
- LOST to HUNT on a strobe

Top module: `fc_field_timer`

## Requirements
- R1: After reset, `std_50` is 1 (1 means 50 Hz, 0 means 60 Hz), `no_sync` is 0, `vout` is 0 and `vblank` is 1.
- R2: The half-line count restarts at 0 in the cycle after a sync strobe and rises by one for each `hl_tick` after that. A tick in the same cycle as a strobe is dropped, so the count stays 0 after that edge.
- R3: A field whose half-line count at the strobe is 576 or more (more than 287 lines) is classified 50 Hz. A count of 575 or less is classified 60 Hz.
- R4: `std_50` changes only in the cycle after a strobe that ends a field in TRACK. It takes the new class only when the previous classified field had the same class. The field that ends the HUNT state is never classified, and the agreement history is forgotten in LOST.
- R5: In TRACK, `vout` is 1 while the count is 0 to 9, and 0 from count 10 on. In every other state it is 0.
- R6: With `std_50`=1 in TRACK, `vblank` is 1 for counts below 45 or at 620 and above (2.5 lines before a 625-half-line field ends, 22.5 lines after the reference).
- R7: With `std_50`=0 in TRACK, `vblank` is 1 for counts below 34 or at 519 and above (3 lines before a 525-half-line field ends, 17 lines after the reference).
- R8: The count saturates at 1023. One cycle after saturation the block enters LOST: `no_sync` is 1, `vblank` is 1 and `vout` is 0. The next strobe clears `no_sync` and moves the block to HUNT.
- R9: In HUNT, `vblank` is 1 and `vout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-cycle strobe at twice line rate |
| vsync_in | input | 1 | One-cycle filtered vertical sync strobe |
| std_50 | output | 1 | Field standard: 1 = 50 Hz, 0 = 60 Hz |
| vout | output | 1 | Vertical output pulse |
| vblank | output | 1 | Vertical blanking window |
| no_sync | output | 1 | Missing-sync flag (LOST state) |

## Verification
A sync strobe and a half-line tick can arrive in the same cycle. Restarting the count and advancing it then compete for the same register, and the strobe must win. The bench provokes this by raising both inputs together partway through a field. It then measures the width of the `vout` pulse that follows: the pulse must stay high for exactly nine more ticks and drop on the tenth, which fixes the count at 0 rather than 1. The field closed by that strobe is also classified, and the resulting flag is checked two fields later.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
    typedef enum logic [1:0] {
        FC_HUNT  = 2'd0,
        FC_TRACK = 2'd1,
        FC_LOST  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_halfline_ctr.sv
`timescale 1ns/1ps
module fc_halfline_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    assign sat = &count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (tick && !sat) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fc_std_track.sv
`timescale 1ns/1ps
module fc_std_track #(
    parameter int CNT_W   = 10,
    parameter int MIN50_HL = 576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_len,
    input  logic             forget,
    output logic             std_50
);
    localparam logic [CNT_W-1:0] MIN50 = CNT_W'(MIN50_HL);

    logic cls_now;
    logic last_cls;
    logic last_vld;

    assign cls_now = (meas_len >= MIN50);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_50   <= 1'b1;
            last_cls <= 1'b1;
            last_vld <= 1'b0;
        end else if (meas_valid) begin
            if (last_vld && (last_cls == cls_now)) begin
                std_50 <= cls_now;
            end
            last_cls <= cls_now;
            last_vld <= 1'b1;
        end else if (forget) begin
            last_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/fc_vwin.sv
`timescale 1ns/1ps
module fc_vwin #(
    parameter int CNT_W     = 10,
    parameter int VOUT_HL   = 10,
    parameter int NOM50_HL  = 625,
    parameter int PRE50_HL  = 5,
    parameter int POST50_HL = 45,
    parameter int NOM60_HL  = 525,
    parameter int PRE60_HL  = 6,
    parameter int POST60_HL = 34
) (
    input  logic [CNT_W-1:0] count,
    input  logic             std_50,
    input  logic             tracking,
    output logic             vout,
    output logic             vblank
);
    localparam logic [CNT_W-1:0] VOUT_END = CNT_W'(VOUT_HL);
    localparam logic [CNT_W-1:0] B50_END  = CNT_W'(POST50_HL);
    localparam logic [CNT_W-1:0] B50_BEG  = CNT_W'(NOM50_HL - PRE50_HL);
    localparam logic [CNT_W-1:0] B60_END  = CNT_W'(POST60_HL);
    localparam logic [CNT_W-1:0] B60_BEG  = CNT_W'(NOM60_HL - PRE60_HL);

    logic [CNT_W-1:0] beg_sel;
    logic [CNT_W-1:0] end_sel;

    always_comb begin
        beg_sel = std_50 ? B50_BEG : B60_BEG;
        end_sel = std_50 ? B50_END : B60_END;
        vout    = tracking && (count < VOUT_END);
        vblank  = !tracking || (count < end_sel) || (count >= beg_sel);
    end
endmodule

// File: rtl/fc_field_timer.sv
`timescale 1ns/1ps
module fc_field_timer #(
    parameter int CNT_W     = 10,
    parameter int MIN50_HL  = 576,
    parameter int VOUT_HL   = 10,
    parameter int NOM50_HL  = 625,
    parameter int PRE50_HL  = 5,
    parameter int POST50_HL = 45,
    parameter int NOM60_HL  = 525,
    parameter int PRE60_HL  = 6,
    parameter int POST60_HL = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hl_tick,
    input  logic vsync_in,
    output logic std_50,
    output logic vout,
    output logic vblank,
    output logic no_sync
);
    import fc_pkg::*;

    fc_state_e        state_q;
    fc_state_e        state_d;
    logic [CNT_W-1:0] count;
    logic             sat;
    logic             meas_valid;
    logic             forget;
    logic             tracking;

    fc_halfline_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (hl_tick),
        .restart (vsync_in),
        .count   (count),
        .sat     (sat)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_HUNT: begin
                if (vsync_in)      state_d = FC_TRACK;
                else if (sat)      state_d = FC_LOST;
            end
            FC_TRACK: begin
                if (vsync_in)      state_d = FC_TRACK;
                else if (sat)      state_d = FC_LOST;
            end
            FC_LOST: begin
                if (vsync_in)      state_d = FC_HUNT;
            end
            default:               state_d = FC_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FC_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        meas_valid = 1'b0;
        forget     = 1'b0;
        tracking   = 1'b0;
        no_sync    = 1'b0;
        unique case (state_q)
            FC_HUNT:  ;
            FC_TRACK: begin
                tracking   = 1'b1;
                meas_valid = vsync_in;
            end
            FC_LOST: begin
                forget  = 1'b1;
                no_sync = 1'b1;
            end
            default:  ;
        endcase
    end

    fc_std_track #(.CNT_W(CNT_W), .MIN50_HL(MIN50_HL)) std_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_len   (count),
        .forget     (forget),
        .std_50     (std_50)
    );

    fc_vwin #(
        .CNT_W     (CNT_W),
        .VOUT_HL   (VOUT_HL),
        .NOM50_HL  (NOM50_HL),
        .PRE50_HL  (PRE50_HL),
        .POST50_HL (POST50_HL),
        .NOM60_HL  (NOM60_HL),
        .PRE60_HL  (PRE60_HL),
        .POST60_HL (POST60_HL)
    ) win_i (
        .count    (count),
        .std_50   (std_50),
        .tracking (tracking),
        .vout     (vout),
        .vblank   (vblank)
    );
endmodule

// File: rtl/fc_field_timer_chk.sv
`timescale 1ns/1ps
module fc_field_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic vsync_in,
    input logic std_50,
    input logic vout,
    input logic vblank,
    input logic no_sync
);
    assert_flag_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_50) |-> $past(vsync_in));

    assert_vout_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_in && !no_sync) |=> vout);

    assert_vout_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vout |-> vblank);

    assert_lost_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_sync |-> (vblank && !vout));

    assert_sync_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_in |=> !no_sync);
endmodule

bind fc_field_timer fc_field_timer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync_in (vsync_in),
    .std_50   (std_50),
    .vout     (vout),
    .vblank   (vblank),
    .no_sync  (no_sync)
);

// File: tb/fc_field_timer_tb_top.sv
`timescale 1ns/1ps
module fc_field_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hl_tick = 1'b0;
    logic vsync_in = 1'b0;
    logic std_50;
    logic vout;
    logic vblank;
    logic no_sync;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int NV = 10;
    localparam int  FLEN [NV] = '{525, 525, 625, 525, 625, 625, 575, 575, 576, 576};
    localparam bit  FEXP [NV] = '{1,   0,   0,   0,   0,   1,   1,   0,   0,   1};

    always #4 clk = ~clk;

    fc_field_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hl_tick  (hl_tick),
        .vsync_in (vsync_in),
        .std_50   (std_50),
        .vout     (vout),
        .vblank   (vblank),
        .no_sync  (no_sync)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            hl_tick = 1'b1;
            @(negedge clk);
        end
        hl_tick = 1'b0;
    endtask

    task automatic vsync(input logic with_tick);
        vsync_in = 1'b1;
        hl_tick  = with_tick;
        @(negedge clk);
        vsync_in = 1'b0;
        hl_tick  = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected below 100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 std_50", std_50, 1'b1);
        chk("R1 no_sync", no_sync, 1'b0);
        chk("R1 vout", vout, 1'b0);
        chk("R1 vblank", vblank, 1'b1);
        // R9 hunting before any reference
        ticks(3);
        chk("R9 vblank", vblank, 1'b1);
        chk("R9 vout", vout, 1'b0);
        vsync(1'b0);
        chk("R5 vout at reference", vout, 1'b1);

        // R3 / R4 field classification table
        for (int v = 0; v < NV; v++) begin
            ticks(FLEN[v]);
            vsync(1'b0);
            chk($sformatf("R3 R4 field %0d len %0d", v, FLEN[v]), std_50, FEXP[v]);
        end

        // R5 pulse width, R6 50 Hz window
        ticks(9);
        chk("R5 vout count 9", vout, 1'b1);
        ticks(1);
        chk("R5 vout count 10", vout, 1'b0);
        ticks(34);
        chk("R6 vblank count 44", vblank, 1'b1);
        ticks(1);
        chk("R6 vblank count 45", vblank, 1'b0);
        ticks(574);
        chk("R6 vblank count 619", vblank, 1'b0);
        ticks(1);
        chk("R6 vblank count 620", vblank, 1'b1);
        vsync(1'b0);

        // R2 strobe and tick in the same cycle
        ticks(9);
        vsync(1'b1);
        chk("R4 short field single 60", std_50, 1'b1);
        ticks(9);
        chk("R2 coincident count 9", vout, 1'b1);
        ticks(1);
        chk("R2 coincident count 10", vout, 1'b0);
        ticks(515);
        vsync(1'b0);
        chk("R4 second 60 field", std_50, 1'b0);

        // R7 60 Hz window
        ticks(33);
        chk("R7 vblank count 33", vblank, 1'b1);
        ticks(1);
        chk("R7 vblank count 34", vblank, 1'b0);
        ticks(484);
        chk("R7 vblank count 518", vblank, 1'b0);
        ticks(1);
        chk("R7 vblank count 519", vblank, 1'b1);
        vsync(1'b0);
        chk("R3 519 is 60", std_50, 1'b0);

        // R8 saturation and recovery
        ticks(625);
        vsync(1'b0);
        chk("R4 single 50 field", std_50, 1'b0);
        ticks(1022);
        chk("R8 no_sync before saturation", no_sync, 1'b0);
        ticks(1);
        @(negedge clk);
        chk("R8 no_sync", no_sync, 1'b1);
        chk("R8 vblank lost", vblank, 1'b1);
        chk("R8 vout lost", vout, 1'b0);
        ticks(5);
        chk("R8 no_sync held", no_sync, 1'b1);
        vsync(1'b0);
        chk("R8 no_sync cleared", no_sync, 1'b0);
        chk("R9 vout in hunt", vout, 1'b0);
        chk("R9 vblank in hunt", vblank, 1'b1);
        ticks(625);
        vsync(1'b0);
        chk("R4 hunt field unclassified", std_50, 1'b0);
        chk("R5 vout after hunt", vout, 1'b1);
        ticks(625);
        vsync(1'b0);
        chk("R8 history forgotten", std_50, 1'b0);
        ticks(625);
        vsync(1'b0);
        chk("R4 agreement after loss", std_50, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule